// File: doc/BRIEF.md
# JTAG Indexed Register Access Port

This block gives an external debug tool read and write access to a small bank of 32-bit internal registers over a four-wire test port. It contains a standard sixteen-state test access port controller clocked by `tck`, a 4-bit instruction register, an access engine and the register bank itself. The access engine is live only while its opcode sits in the instruction register. Any other opcode leaves a one-bit bypass stage in the data path.

Each transaction takes two data-register scans. The first is an 8-bit command. Bits 7:1 of the command give the register index and bit 0 gives the direction: 0 means read and 1 means write. The second scan is 32 bits and carries the data least significant bit first. On a read, the register value is captured on Capture-DR and shifted out. On a write, the shifted value is committed on Update-DR. Two events cancel a pending transaction: the controller passing through Test-Logic-Reset (by TMS or by `trst_n`), and a power-on reset. Power-on reset also clears the register bank.

Top module: `jtag_regport`

## Requirements
- R1: The access path works only while the instruction register holds the access opcode 4'b1010. With any other instruction, for example 4'b1111, the data path is a single bypass bit that captures 0, and no register can be written.
- R2: Every Update-DR under the access opcode toggles the engine between its command phase and its data phase. The phase therefore alternates 8-bit command scan, 32-bit data scan, command scan, and so on.
- R3: The command scan is 8 bits, shifted least significant bit first. Bits 7:1 are the register index and bit 0 is the direction (0 read, 1 write). Capture-DR in the command phase loads zeros.
- R4: In a read data scan, Capture-DR loads the selected register, and its 32 bits appear on `tdo` least significant bit first.
- R5: In a write data scan, Capture-DR loads zeros. The 32 bits shifted in on `tdi` (least significant bit first) are written to the selected register on Update-DR, and at no other time.
- R6: Entering Test-Logic-Reset, whether by five TMS ones or by driving `trst_n` low, does three things. It selects the bypass opcode, returns the engine to the command phase, and drops a half-finished transaction. Register contents are kept.
- R7: Driving `por_n` low clears every register to 0 and puts the controller in Test-Logic-Reset.
- R8: Completing an instruction scan (Update-IR) returns the engine to the command phase.
- R9: The bank has 4 registers (indices 0 to 3). Any other index reads as 0, and a write to it changes no register.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR, and `tdo` is 0 whenever `tdo_en` is 0.
- R11: The instruction register is 4 bits, shifted least significant bit first. Capture-IR loads 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| por_n | input | 1 | Asynchronous power-on reset, active low; also clears the bank |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` in shift states |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |

## Verification
The hidden state that matters most is the command/data phase bit. If it is wrong, the very next scan at the ports is misread: a 32-bit data scan is taken as a command, or an 8-bit command is committed as data. The error shows as a wrong value on `tdo` in the following read, within one transaction. A stale instruction register or a missed Test-Logic-Reset shows in the first data scan afterwards. That scan either returns bypass-delayed bits or register data where the other was expected. Write strobes at the wrong time or to the wrong index appear only on a later read-back, so each write is followed by reads of the written register and its neighbours.

// File: rtl/jrp_pkg.sv
package jrp_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_t;

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  // Next controller state from the current state and tms.
  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
      default:     n = m ? TS_SEL_DR   : TS_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [CMD_W-2:0] cmd_index(input logic [CMD_W-1:0] c);
    return c[CMD_W-1:1];
  endfunction

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return c[0];
  endfunction

endpackage

// File: rtl/jrp_tap.sv
module jrp_tap
  import jrp_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state,
  output logic       in_tlr,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       upd_dr,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       upd_ir
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= tap_next(state, tms);
  end

  assign in_tlr = (state == TS_RESET);
  assign cap_dr = (state == TS_CAP_DR);
  assign sh_dr  = (state == TS_SHIFT_DR);
  assign upd_dr = (state == TS_UPD_DR);
  assign cap_ir = (state == TS_CAP_IR);
  assign sh_ir  = (state == TS_SHIFT_IR);
  assign upd_ir = (state == TS_UPD_IR);

endmodule

// File: rtl/jrp_ir.sv
module jrp_ir #(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] ACC_OP = 4'b1010
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic in_tlr,
  input  logic cap_ir,
  input  logic sh_ir,
  input  logic upd_ir,
  output logic ir_tdo,
  output logic access_on
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] BYP_OP  = '1;

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= '0;
      ir_q  <= BYP_OP;
    end else begin
      if (cap_ir)     ir_sr <= CAP_PAT;
      else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (in_tlr)      ir_q <= BYP_OP;
      else if (upd_ir) ir_q <= ir_sr;
    end
  end

  assign ir_tdo    = ir_sr[0];
  assign access_on = (ir_q == ACC_OP);

endmodule

// File: rtl/jrp_engine.sv
module jrp_engine
  import jrp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = CMD_W - 1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              in_tlr,
  input  logic              upd_ir,
  input  logic              cap_dr,
  input  logic              sh_dr,
  input  logic              upd_dr,
  input  logic              access_on,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              dr_tdo,
  output phase_t            phase,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata
);

  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sr;
  logic [DATA_W:0]   sr_ext;
  logic [DATA_W-1:0] sr_nxt;
  logic [LEN_W-1:0]  len;
  logic              cmd_wr;
  logic [IDX_W-1:0]  cmd_idx;

  // Active scan length: bypass bit, command or data word.
  always_comb begin
    if (!access_on)          len = LEN_W'(1);
    else if (phase == PH_CMD) len = LEN_W'(CMD_W);
    else                     len = LEN_W'(DATA_W);
  end

  // tdi enters at the top of the active length, bit 0 leaves first.
  assign sr_ext = {1'b0, sr};
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      sr_nxt[i] = (i == int'(len) - 1) ? tdi : sr_ext[i+1];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      phase   <= PH_CMD;
      cmd_idx <= '0;
      cmd_wr  <= 1'b0;
    end else begin
      if (in_tlr || upd_ir) begin
        phase <= PH_CMD;
      end else if (upd_dr && access_on) begin
        if (phase == PH_CMD) begin
          cmd_idx <= cmd_index(sr[CMD_W-1:0]);
          cmd_wr  <= cmd_is_write(sr[CMD_W-1:0]);
          phase   <= PH_DATA;
        end else begin
          phase   <= PH_CMD;
        end
      end
      if (cap_dr)
        sr <= (access_on && phase == PH_DATA && !cmd_wr) ? reg_rdata : '0;
      else if (sh_dr)
        sr <= sr_nxt;
    end
  end

  assign dr_tdo    = sr[0];
  assign reg_idx   = cmd_idx;
  assign reg_wdata = sr;
  assign reg_we    = upd_dr && access_on && (phase == PH_DATA) && cmd_wr;

endmodule

// File: rtl/jrp_regfile.sv
module jrp_regfile #(
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                          regs[g] <= '0;
      else if (we && (int'(idx) == g))     regs[g] <= wdata;
    end
  end

  // Indices outside the bank fall through to zero.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(idx) == i) rdata = regs[i];
  end

endmodule

// File: rtl/jtag_regport.sv
module jtag_regport
  import jrp_pkg::*;
#(
  parameter int              NREG   = 4,
  parameter int              DATA_W = 32,
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] ACC_OP = 4'b1010
) (
  input  logic tck,
  input  logic trst_n,
  input  logic por_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en
);

  localparam int IDX_W = CMD_W - 1;

  logic              rst_n;
  tap_state_t        tap_state;
  logic              in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
  logic              ir_tdo, dr_tdo, access_on;
  phase_t            phase;
  logic [IDX_W-1:0]  reg_idx;
  logic              reg_we;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              tdo_q, tdo_en_q;

  assign rst_n = trst_n & por_n;

  jrp_tap u_tap (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_state),
    .in_tlr(in_tlr), .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
  );

  jrp_ir #(.IR_W(IR_W), .ACC_OP(ACC_OP)) u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .in_tlr(in_tlr),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .ir_tdo(ir_tdo), .access_on(access_on)
  );

  jrp_engine #(.DATA_W(DATA_W)) u_eng (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .in_tlr(in_tlr), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr), .access_on(access_on),
    .reg_rdata(reg_rdata), .dr_tdo(dr_tdo), .phase(phase),
    .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata)
  );

  jrp_regfile #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .tck(tck), .por_n(por_n), .we(reg_we), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata)
  );

  // Output stage moves on the falling edge, half a cycle after the shift.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= sh_ir | sh_dr;
      tdo_q    <= sh_ir ? ir_tdo : (sh_dr ? dr_tdo : 1'b0);
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = tdo_en_q;

endmodule

// File: rtl/jrp_checker.sv
module jrp_checker
  import jrp_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input logic              tck,
  input logic              rst_n,
  input tap_state_t        state,
  input phase_t            phase,
  input logic              access_on,
  input logic              reg_we,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              tdo_en,
  input logic              upd_dr,
  input logic              in_tlr
);

  assert_we_needs_access_R1: assert property (@(posedge tck) disable iff (!rst_n)
    reg_we |-> access_on);

  assert_phase_flips_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (upd_dr && access_on) |=> (phase != $past(phase)));

  assert_we_at_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
    reg_we |-> (state == TS_UPD_DR));

  assert_tlr_clears_R6: assert property (@(posedge tck) disable iff (!rst_n)
    in_tlr |=> (phase == PH_CMD && !access_on));

  assert_unimpl_zero_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (int'(reg_idx) >= NREG) |-> (reg_rdata == '0));

  assert_tdo_en_shift_R10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (state == TS_SHIFT_DR || state == TS_SHIFT_IR));

endmodule

bind jtag_regport jrp_checker #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .state(tap_state), .phase(phase),
  .access_on(access_on), .reg_we(reg_we), .reg_idx(reg_idx),
  .reg_rdata(reg_rdata), .tdo_en(tdo_en), .upd_dr(upd_dr), .in_tlr(in_tlr)
);

// File: tb/jtag_regport_bench.sv
module jtag_regport_bench;

  localparam int PERIOD = 10;
  localparam logic [3:0] OP_ACC = 4'b1010;
  localparam logic [3:0] OP_BYP = 4'b1111;

  // {write, index[6:0], shifted data[31:0], expected tdo word[31:0]}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 7'd0, 32'hDEADBEEF, 32'h00000000},
    {1'b1, 7'd1, 32'h12345678, 32'h00000000},
    {1'b0, 7'd0, 32'h00000000, 32'hDEADBEEF},
    {1'b0, 7'd1, 32'hFFFFFFFF, 32'h12345678},
    {1'b1, 7'd3, 32'h80000001, 32'h00000000},
    {1'b0, 7'd3, 32'h00000000, 32'h80000001},
    {1'b0, 7'd2, 32'h5A5A5A5A, 32'h00000000},
    {1'b1, 7'd2, 32'hFFFFFFFF, 32'h00000000},
    {1'b0, 7'd2, 32'h00000000, 32'hFFFFFFFF},
    {1'b1, 7'd0, 32'h00000000, 32'h00000000},
    {1'b0, 7'd0, 32'h00000000, 32'h00000000},
    {1'b0, 7'd3, 32'h00000000, 32'h80000001}
  };

  logic tck = 1'b0, trst_n = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;

  int total = 0, bad = 0;
  bit done = 0;
  logic early_tdo, early_en, late_tdo;
  bit unstable;

  jtag_regport u_jtag_regport (
    .tck(tck), .trst_n(trst_n), .por_n(por_n),
    .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en)
  );

  always #(PERIOD/2) tck = ~tck;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One tck cycle: sample outputs after the falling edge, then drive tms/tdi.
  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    early_tdo = tdo;
    early_en  = tdo_en;
    tms = m; tdi = d;
    @(posedge tck); #1;
    late_tdo = tdo;
    if (late_tdo !== early_tdo) unstable = 1;
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [3:0] v, output logic [3:0] o);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, v[i]);
      o[i] = early_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] v, output logic [31:0] o, output logic en_ok);
    o = '0;
    en_ok = 1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, v[i]);
      o[i] = early_tdo;
      if (early_en !== 1'b1) en_ok = 0;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic xact(input logic wr, input logic [6:0] idx, input logic [31:0] d,
                      output logic [31:0] cmd_out, output logic [31:0] dat_out);
    logic e;
    scan_dr(8, {24'd0, idx, wr}, cmd_out, e);
    scan_dr(32, d, dat_out, e);
  endtask

  task automatic read_check(input logic [6:0] idx, input logic [31:0] exp, input string tag);
    logic [31:0] c, o;
    xact(1'b0, idx, 32'h0, c, o);
    check(o === exp, tag, o, exp);
  endtask

  function automatic logic [31:0] bypass_expect(input logic [7:0] p);
    logic [31:0] r = '0;
    for (int i = 1; i < 8; i++) r[i] = p[i-1];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  iro;
    logic [31:0] co, dout;
    logic        en_ok;
    logic [7:0]  pat;

    repeat (3) @(posedge tck);
    #2; por_n = 1'b1; trst_n = 1'b1;
    #1;
    // R7 R10: reset state is quiet
    check(tdo_en === 1'b0, "R10 reset tdo_en", {31'd0, tdo_en}, 0);
    check(tdo === 1'b0, "R7 reset tdo", {31'd0, tdo}, 0);
    tms_reset();

    // R11: capture pattern on instruction load
    scan_ir(OP_ACC, iro);
    check(iro === 4'b0001, "R11 ir capture", {28'd0, iro}, 32'h1);

    // R2 R3 R4 R5: vector walk
    for (int k = 0; k < NV; k++) begin
      unstable = 0;
      xact(VEC[k][71], VEC[k][70:64], VEC[k][63:32], co, dout);
      check(co[7:0] === 8'h00, "R3 command capture zero", co, 0);
      check(dout === VEC[k][31:0], VEC[k][71] ? "R5 write scan" : "R4 read scan", dout, VEC[k][31:0]);
      if (k == 2) check(!unstable, "R10 tdo held across rising edge", {31'd0, unstable}, 0);
    end

    // R10: shift enable seen during scan, idle afterwards
    scan_dr(8, 32'h0, co, en_ok);
    check(en_ok === 1'b1, "R10 tdo_en in shift", {31'd0, en_ok}, 1);
    #1 check(tdo_en === 1'b0 && tdo === 1'b0, "R10 idle outputs", {30'd0, tdo_en, tdo}, 0);
    scan_dr(32, 32'h0, co, en_ok);  // finish the data phase opened above (read idx 0)

    // R9: indices past the bank
    xact(1'b1, 7'd4, 32'hAAAA5555, co, dout);
    read_check(7'd4, 32'h0, "R9 idx4 reads zero");
    xact(1'b1, 7'd127, 32'h13572468, co, dout);
    read_check(7'd127, 32'h0, "R9 idx127 reads zero");
    read_check(7'd3, 32'h80000001, "R9 bank untouched r3");
    read_check(7'd0, 32'h00000000, "R9 bank untouched r0");

    // R8: instruction load drops the data phase
    scan_dr(8, {24'd0, 7'd1, 1'b1}, co, en_ok);
    scan_ir(OP_ACC, iro);
    read_check(7'd1, 32'h12345678, "R8 phase back to command");

    // R6: TMS reset mid-transaction
    scan_dr(8, {24'd0, 7'd2, 1'b1}, co, en_ok);
    tms_reset();
    pat = 8'b1011_0010;
    scan_dr(8, {24'd0, pat}, co, en_ok);
    check(co === bypass_expect(pat), "R6 bypass after tms reset", co, bypass_expect(pat));
    scan_ir(OP_ACC, iro);
    read_check(7'd2, 32'hFFFFFFFF, "R6 register kept after tms reset");

    // R6: trst_n in the middle of a write data scan
    scan_dr(8, {24'd0, 7'd3, 1'b1}, co, en_ok);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) step(0, 1);
    trst_n = 1'b0; #(PERIOD*2); trst_n = 1'b1;
    tms_reset();
    scan_ir(OP_ACC, iro);
    read_check(7'd3, 32'h80000001, "R6 trst drops write");

    // R1: other instruction gives bypass and no writes
    scan_ir(OP_BYP, iro);
    pat = 8'b0110_1101;
    scan_dr(8, {24'd0, 7'd1, 1'b1}, co, en_ok);
    scan_dr(32, 32'h0BADF00D, co, en_ok);
    scan_dr(8, {24'd0, pat}, co, en_ok);
    check(co === bypass_expect(pat), "R1 bypass data path", co, bypass_expect(pat));
    scan_ir(OP_ACC, iro);
    read_check(7'd1, 32'h12345678, "R1 no write under bypass");

    // R7: power-on reset clears the bank
    por_n = 1'b0; #(PERIOD*2); por_n = 1'b1;
    #1 check(tdo_en === 1'b0, "R7 por quiet outputs", {31'd0, tdo_en}, 0);
    tms_reset();
    scan_ir(OP_ACC, iro);
    read_check(7'd1, 32'h0, "R7 por clears r1");
    read_check(7'd2, 32'h0, "R7 por clears r2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule